// File: doc/BRIEF.md
# Biphase Mark Code Frame Transmit Encoder

This block puts a complete power-delivery style frame onto one wire in Biphase Mark Code. It runs from the system clock and moves the line only on a half-bit enable pulse, which the surrounding logic produces at twice the data rate. For 300 kbit/s that is 600 kHz. After a frame is started it sends a fixed 128 half-bit alternating preamble. It then takes line symbols one at a time from a valid/ready port. Each symbol arrives as ten half-bit values, already coded and expanded, and the block inverts it where needed so the line level carries on unbroken from one symbol into the next.

When a symbol flagged as last has been sent, the block closes the frame. It makes one final transition that leaves the line low, then holds a low trailer. After the trailer it drops the output enable and pulses done. If no symbol is waiting at a symbol boundary, the block stalls and holds the line where it is. Code-group lookup and CRC generation take place upstream.

Top module: `bmc_tx_encoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, line_out, line_oe, busy, done and sym_ready are all 0.
- R2: A frame_start pulse while idle makes busy 1 in the next cycle. The next 128 half-bit ticks then drive line_out, LSB first, with bit (n mod 32) of the 32-bit word B4B4B4B4 hex, so the first half-bit is 0 and the last is 1. line_oe rises with the first of these half-bits.
- R3: line_out and line_oe change only in the cycle that follows a cycle in which hb_tick is 1.
- R4: sym_ready is 1 only after the preamble and only while no symbol is being sent. A symbol is taken in a cycle with sym_valid and sym_ready both 1. sym_hb, sym_last and sym_valid have no effect in any other cycle.
- R5: A taken symbol is sent as sym_hb XOR a ten-bit mask, bit 0 first, one bit per tick. The mask is all ones for the first symbol after the preamble.
- R6: The mask for each later symbol is all ones if bit 9 of the previously sent (inverted) value was 1, and all zeros if it was 0.
- R7: A tick that arrives at a symbol boundary with no symbol taken leaves line_out and line_oe unchanged and sends nothing.
- R8: After the last symbol, the next tick drives the inverse of the current line level. The following 1 + TRAIL_HB ticks drive 0. A line ending at 0 therefore closes with 1 then 0, and a line ending at 1 closes with 0 then 0.
- R9: The tick after the trailer drops line_oe and busy. done is 1 in exactly that next cycle and in no other.
- R10: frame_start has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begins a frame when idle |
| hb_tick | input | 1 | Half-bit enable, one pulse per half-bit period |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Block can take a symbol |
| sym_hb | input | SYM_W (10) | Symbol as half-bit values, bit 0 sent first |
| sym_last | input | 1 | Offered symbol ends the frame |
| line_out | output | 1 | Serial line level |
| line_oe | output | 1 | Request to drive the line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame completion |

## Verification
The hardest cases to reach are the ones where symbol delivery and tick timing collide. In one, a tick lands at a symbol boundary before the next symbol has been taken. In another, a tick falls in the same cycle as the handshake. In both, the line must hold its level rather than advance. The stimulus reaches these cases by running ticks on every clock and holding back symbols for several cycles. A second run spaces the ticks several clocks apart, which changes where the handshake falls relative to the tick.

Two single-symbol frames are chosen so that the final line level is 1 in one and 0 in the other, which exercises both end-edge outcomes. A frame_start is also pulsed in the middle of a frame. A behavioural queue model of the half-bits predicts every output on every clock.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_END   = 3'd4
  } bmc_state_e;

  localparam int unsigned PRE_WORD_W = 32;
endpackage

// File: rtl/bmc_tx_pre_rom.sv
module bmc_tx_pre_rom #(
  parameter logic [31:0] PRE_WORD = 32'hB4B4B4B4,
  parameter int unsigned SEL_W    = 5
) (
  input  logic [SEL_W-1:0] sel,
  output logic             pre_bit
);
  // preamble half-bit n is word bit (n mod 32): LSB goes on the wire first
  assign pre_bit = PRE_WORD[sel];
endmodule

// File: rtl/bmc_tx_polarity.sv
module bmc_tx_polarity #(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             accept,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] sym_out,
  output logic             mask_q
);
  // one stored bit stands for the whole all-ones / all-zeros mask
  assign sym_out = sym_in ^ {SYM_W{mask_q}};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
    end else if (arm) begin
      mask_q <= 1'b1;
    end else if (accept) begin
      mask_q <= sym_out[SYM_W-1];
    end
  end

  // R5: a fresh frame leaves the mask at all ones
  a_r5_mask_armed: assert property (@(posedge clk) disable iff (rst)
    arm |=> mask_q);
endmodule

// File: rtl/bmc_tx_seq.sv
module bmc_tx_seq
  import bmc_tx_pkg::*;
#(
  parameter int unsigned SYM_W    = 10,
  parameter int unsigned PRE_HB   = 128,
  parameter int unsigned TRAIL_HB = 4,
  parameter int unsigned SEL_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             sym_valid,
  input  logic             sym_last,
  input  logic [SYM_W-1:0] sym_x,
  input  logic             pre_bit,
  output logic [SEL_W-1:0] pre_sel,
  output logic             arm,
  output logic             accept,
  output logic             sym_ready,
  output logic             line_out,
  output logic             line_oe,
  output logic             busy,
  output logic             done
);
  localparam int unsigned END_TICKS = TRAIL_HB + 3;
  localparam int unsigned MAX_A = (PRE_HB > SYM_W) ? PRE_HB : SYM_W;
  localparam int unsigned MAX_B = (MAX_A > END_TICKS) ? MAX_A : END_TICKS;
  localparam int unsigned CNT_RAW = $clog2(MAX_B + 1);
  localparam int unsigned CNT_W = (CNT_RAW > SEL_W) ? CNT_RAW : SEL_W;
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_HB - 1);
  localparam logic [CNT_W-1:0] SYM_LAST = CNT_W'(SYM_W - 1);
  localparam logic [CNT_W-1:0] END_LAST = CNT_W'(END_TICKS - 1);

  bmc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SYM_W-1:0] shreg_q;
  logic             last_q;
  logic             line_q;
  logic             oe_q;
  logic             done_q;

  assign pre_sel   = cnt_q[SEL_W-1:0];
  assign arm       = start && (state_q == ST_IDLE);
  assign sym_ready = (state_q == ST_WAIT);
  assign accept    = sym_ready && sym_valid;
  assign line_out  = line_q;
  assign line_oe   = oe_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      last_q  <= 1'b0;
      line_q  <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
          end
        end
        ST_PRE: begin
          if (tick) begin
            line_q <= pre_bit;
            oe_q   <= 1'b1;
            if (cnt_q == PRE_LAST) begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          // a tick here is a stall: the line keeps its level
          if (sym_valid) begin
            shreg_q <= sym_x;
            last_q  <= sym_last;
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            line_q  <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            if (cnt_q == SYM_LAST) begin
              cnt_q   <= '0;
              state_q <= last_q ? ST_END : ST_WAIT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_END: begin
          if (tick) begin
            if (cnt_q == END_LAST) begin
              oe_q    <= 1'b0;
              line_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
              cnt_q   <= '0;
            end else begin
              line_q <= (cnt_q == '0) ? ~line_q : 1'b0;
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a symbol can only be offered into a running frame
  a_r4_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
    sym_ready |-> busy);

  // R8: with the driver released the line rests low
  a_r8_low_when_released: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> !line_out);
endmodule

// File: rtl/bmc_tx_encoder.sv
module bmc_tx_encoder #(
  parameter int unsigned SYM_W    = 10,
  parameter int unsigned PRE_HB   = 128,
  parameter int unsigned TRAIL_HB = 4,
  parameter logic [31:0] PRE_WORD = 32'hB4B4B4B4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             hb_tick,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_hb,
  input  logic             sym_last,
  output logic             line_out,
  output logic             line_oe,
  output logic             busy,
  output logic             done
);
  localparam int unsigned SEL_W = $clog2(bmc_tx_pkg::PRE_WORD_W);

  logic [SEL_W-1:0] pre_sel;
  logic             pre_bit;
  logic             arm;
  logic             accept;
  logic [SYM_W-1:0] sym_x;
  logic             mask_q;

  bmc_tx_pre_rom #(
    .PRE_WORD (PRE_WORD),
    .SEL_W    (SEL_W)
  ) u_pre (
    .sel     (pre_sel),
    .pre_bit (pre_bit)
  );

  bmc_tx_polarity #(
    .SYM_W (SYM_W)
  ) u_pol (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .accept  (accept),
    .sym_in  (sym_hb),
    .sym_out (sym_x),
    .mask_q  (mask_q)
  );

  bmc_tx_seq #(
    .SYM_W    (SYM_W),
    .PRE_HB   (PRE_HB),
    .TRAIL_HB (TRAIL_HB),
    .SEL_W    (SEL_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (frame_start),
    .tick      (hb_tick),
    .sym_valid (sym_valid),
    .sym_last  (sym_last),
    .sym_x     (sym_x),
    .pre_bit   (pre_bit),
    .pre_sel   (pre_sel),
    .arm       (arm),
    .accept    (accept),
    .sym_ready (sym_ready),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .busy      (busy),
    .done      (done)
  );

  // R3: the line moves only on half-bit ticks
  a_r3_line_on_tick: assert property (@(posedge clk) disable iff (rst)
    !hb_tick |=> ($stable(line_out) && $stable(line_oe)));

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: releasing the line coincides with done
  a_r9_release_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> (done && !busy));
endmodule

// File: tb/bmc_tx_encoder_bench.sv
module bmc_tx_encoder_bench;
  localparam int SYM_W    = 10;
  localparam int PRE_HB   = 128;
  localparam int TRAIL_HB = 4;
  localparam logic [31:0] PRE_WORD = 32'hB4B4B4B4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_start = 1'b0;
  logic             hb_tick = 1'b0;
  logic             sym_valid = 1'b0;
  logic [SYM_W-1:0] sym_hb = '0;
  logic             sym_last = 1'b0;
  logic             sym_ready, line_out, line_oe, busy, done;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int tick_period = 3;
  int tcnt = 0;

  always #4 clk = ~clk; // 125 MHz

  bmc_tx_encoder #(
    .SYM_W (SYM_W), .PRE_HB (PRE_HB), .TRAIL_HB (TRAIL_HB), .PRE_WORD (PRE_WORD)
  ) u_bmc_tx_encoder (
    .clk (clk), .rst (rst), .frame_start (frame_start), .hb_tick (hb_tick),
    .sym_valid (sym_valid), .sym_ready (sym_ready), .sym_hb (sym_hb),
    .sym_last (sym_last), .line_out (line_out), .line_oe (line_oe),
    .busy (busy), .done (done)
  );

  // reference model: a queue of pending half-bits, each with a requirement tag
  bit q_bit[$];
  int q_tag[$];
  bit m_busy, m_line, m_oe, m_done, m_ready, m_mask, m_fin;
  int m_tag = 1;

  always @(posedge clk) begin
    if (rst) begin
      q_bit.delete(); q_tag.delete();
      m_busy = 0; m_line = 0; m_oe = 0; m_done = 0; m_ready = 0;
      m_mask = 0; m_fin = 0; m_tag = 1;
    end else begin
      bit acc;
      acc = m_ready && sym_valid;   // R4: only while ready
      m_done = 0;
      if (!m_busy) begin
        if (frame_start) begin      // R2 start; R10 ignored otherwise
          m_busy = 1; m_mask = 1; m_fin = 0; m_tag = 2;
          for (int i = 0; i < PRE_HB; i++) begin
            q_bit.push_back(PRE_WORD[i % 32]); q_tag.push_back(2);
          end
        end
      end else begin
        if (hb_tick) begin
          if (q_bit.size() > 0) begin
            m_line = q_bit.pop_front(); m_tag = q_tag.pop_front(); m_oe = 1;
          end else if (m_fin) begin // R9
            m_oe = 0; m_line = 0; m_done = 1; m_busy = 0; m_tag = 9;
          end else begin
            m_tag = 7;              // R7 stall: hold
          end
        end
        if (acc) begin
          logic [SYM_W-1:0] x;
          x = sym_hb ^ (m_mask ? {SYM_W{1'b1}} : {SYM_W{1'b0}}); // R5
          for (int i = 0; i < SYM_W; i++) begin
            q_bit.push_back(x[i]); q_tag.push_back(5);
          end
          m_mask = x[SYM_W-1];      // R6
          if (sym_last) begin       // R8 end edge and trailer
            m_fin = 1;
            q_bit.push_back(~x[SYM_W-1]); q_tag.push_back(8);
            for (int i = 0; i < TRAIL_HB + 1; i++) begin
              q_bit.push_back(1'b0); q_tag.push_back(8);
            end
          end
        end
      end
      m_ready = m_busy && !m_fin && (q_bit.size() == 0);
    end
  end

  task automatic summary_and_finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if ({line_out, line_oe, busy, done, sym_ready} !=
          {m_line, m_oe, m_busy, m_done, m_ready}) begin
        mismatched++;
        $display("FAIL R%0d t=%0t actual line/oe/busy/done/ready=%b expected=%b",
                 m_tag, $time, {line_out, line_oe, busy, done, sym_ready},
                 {m_line, m_oe, m_busy, m_done, m_ready});
      end
    end
  end

  // half-bit tick generator (R3 exercised by gaps between ticks)
  always @(negedge clk) begin
    if (rst) begin
      hb_tick <= 1'b0; tcnt = 0;
    end else begin
      tcnt++;
      if (tcnt >= tick_period) begin hb_tick <= 1'b1; tcnt = 0; end
      else hb_tick <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary_and_finish();
    end
  end

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // R4: sym_valid is held through non-ready cycles; those must be ignored
  task automatic send_sym(input logic [SYM_W-1:0] d, input bit last);
    sym_valid = 1'b1; sym_hb = d; sym_last = last;
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 1'b0; sym_last = 1'b1; sym_hb = ~d; // ignored garbage
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    compared++;
    if ({line_out, line_oe, busy, done, sym_ready} != 5'b0) begin
      mismatched++;
      $display("FAIL R1 reset actual=%b expected=00000",
               {line_out, line_oe, busy, done, sym_ready});
    end
    rst = 1'b0;
    @(negedge clk);

    // frame A: spaced ticks, prompt symbols, mask chain R5 R6
    tick_period = 3;
    pulse_start();
    send_sym(10'h0F3, 0);
    send_sym(10'h2A5, 0);
    send_sym(10'h31C, 0);
    send_sym(10'h16A, 1);
    wait_done();

    // frame B: tick every clock, delayed symbols R7, start while busy R10
    tick_period = 1;
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    send_sym(10'h3C5, 0);
    repeat (15) @(negedge clk);
    send_sym(10'h09A, 0);
    repeat (7) @(negedge clk);
    send_sym(10'h255, 1);
    wait_done();

    // frame C: single symbol, bit9=0 -> sent bit9=1 -> end 0,0 (R8)
    tick_period = 2;
    pulse_start();
    send_sym(10'h155, 1);
    wait_done();

    // frame D: single symbol, bit9=1 -> sent bit9=0 -> end 1,0 (R8)
    pulse_start();
    send_sym(10'h2AA, 1);
    wait_done();

    // frame E: slow ticks, longer frame
    tick_period = 5;
    pulse_start();
    for (int i = 0; i < 6; i++) send_sym(SYM_W'(37 * i + 11), 0);
    send_sym(10'h1E7, 1);
    wait_done();

    repeat (5) @(negedge clk);
    summary_and_finish();
  end
endmodule